// File: doc/BRIEF.md
# Keyed SHA-1 Message Authentication Engine

This block produces a 160-bit message authentication code by running exactly one SHA-1 compression over a 512-bit block that it builds itself. The block is formed from three inputs: a 64-bit stored key, a 64-bit host challenge, and a 64-bit field. That field is either the device address or all ones, depending on a mode input. The rest of the block is fixed constant data. A host first loads a challenge through a load strobe and then pulses start. About eighty clock cycles later, the digest is presented together with a one-cycle done flag.

The block holds the challenge in a register that clears on reset. A run started before any challenge load therefore hashes a zero challenge. The constant words are chosen so that the block is a correctly padded single-block SHA-1 message of 24 bytes. A host can therefore reproduce the code with any standard SHA-1 routine over the byte string key, challenge, field.

Top module: `keyed_sha1_mac`

## Requirements
- R1: After reset, `done` is 0 and `digest` is all zeros.
- R2: With `use_addr`=0, the 16 big-endian message words are as follows: W0..W1 = key[63:0] (high word first), W2..W3 = stored challenge, W4..W5 = 32'hFFFFFFFF, W6 = 32'h80000000, W7..W14 = 0 and W15 = 32'd192. `digest` equals the SHA-1 compression of this block from the standard initial values, with H0 in digest[159:128] and H4 in digest[31:0].
- R3: With `use_addr`=1, W4..W5 carry dev_addr[63:0] (high word first) instead of all ones. All other words are as in R2.
- R4: If no challenge has been loaded since reset, the stored challenge is zero.
- R5: A one-cycle `chal_load` stores `chal_in`, and later runs use the most recently stored value.
- R6: When `start` is accepted at clock edge k, `done` is 1 for exactly the one cycle after edge k+80, and the new `digest` is valid from that same edge.
- R7: A `start` pulse that arrives while a run is in progress is ignored. It produces no extra `done` and does not alter the current result.
- R8: `digest` holds its value between completions, whatever the inputs do.
- R9: The key, challenge, address and mode are captured when `start` is accepted. Changes to them during a run, including a `chal_load`, do not affect that run's digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key | input | 64 | Stored secret |
| chal_in | input | 64 | Challenge value to store |
| chal_load | input | 1 | Stores `chal_in` into the challenge register |
| dev_addr | input | 64 | Device address for the address-included mode |
| use_addr | input | 1 | 1: address in W4..W5; 0: all ones |
| start | input | 1 | Begins a run when idle |
| digest | output | 160 | Result code, H0 in the top bits |
| done | output | 1 | One-cycle flag marking a new digest |

## Verification
Only the digest is a result here, and it is due with `done` exactly 81 bench cycles after the cycle in which the driver raises `start`. That is one edge to accept the run and eighty round edges. The driver records the cycle count when it raises `start` and queues the expected digest together with that due cycle. The monitor samples on falling edges and, on each `done`, compares both the value and the arrival cycle. A `done` that arrives with nothing queued is an error, and that is how ignored starts are caught.

// File: rtl/keyed_sha1_mac.sv
module keyed_sha1_mac #(
  parameter int ROUNDS = 80,
  parameter int NWORDS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [63:0]  key,
  input  logic [63:0]  chal_in,
  input  logic         chal_load,
  input  logic [63:0]  dev_addr,
  input  logic         use_addr,
  input  logic         start,
  output logic [159:0] digest,
  output logic         done
);
  localparam int CW = $clog2(ROUNDS);
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);
  localparam logic [31:0] IV0 = 32'h67452301, IV1 = 32'hEFCDAB89,
                          IV2 = 32'h98BADCFE, IV3 = 32'h10325476,
                          IV4 = 32'hC3D2E1F0;

  logic [63:0]   chal_q;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [31:0]   a, b, c, d, e;
  logic [31:0]   w [NWORDS];
  logic [31:0]   blk [NWORDS];
  logic [31:0]   f, kc, tmp, mix, wnew;

  always_ff @(posedge clk)
    if (!rst_n) chal_q <= '0;
    else if (chal_load) chal_q <= chal_in;

  always_comb begin
    for (int i = 0; i < NWORDS; i++) blk[i] = 32'h0;
    blk[0] = key[63:32];
    blk[1] = key[31:0];
    blk[2] = chal_q[63:32];
    blk[3] = chal_q[31:0];
    blk[4] = use_addr ? dev_addr[63:32] : 32'hFFFF_FFFF;
    blk[5] = use_addr ? dev_addr[31:0]  : 32'hFFFF_FFFF;
    blk[6] = 32'h8000_0000;
    blk[NWORDS-1] = 32'd192;
  end

  always_comb begin
    if (cnt < CW'(20)) begin
      f = (b & c) | (~b & d);            kc = 32'h5A827999;
    end else if (cnt < CW'(40)) begin
      f = b ^ c ^ d;                     kc = 32'h6ED9EBA1;
    end else if (cnt < CW'(60)) begin
      f = (b & c) | (b & d) | (c & d);   kc = 32'h8F1BBCDC;
    end else begin
      f = b ^ c ^ d;                     kc = 32'hCA62C1D6;
    end
    tmp = {a[26:0], a[31:27]} + f + e + kc + w[0];
  end

  assign mix  = w[13] ^ w[8] ^ w[2] ^ w[0];
  assign wnew = {mix[30:0], mix[31]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      digest <= '0;
      {a, b, c, d, e} <= '0;
      for (int i = 0; i < NWORDS; i++) w[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          {a, b, c, d, e} <= {IV0, IV1, IV2, IV3, IV4};
          for (int i = 0; i < NWORDS; i++) w[i] <= blk[i];
        end
      end else begin
        a <= tmp;
        b <= a;
        c <= {b[1:0], b[31:2]};
        d <= c;
        e <= d;
        for (int i = 0; i < NWORDS-1; i++) w[i] <= w[i+1];
        w[NWORDS-1] <= wnew;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          digest <= {IV0 + tmp, IV1 + a, IV2 + {b[1:0], b[31:2]}, IV3 + c, IV4 + d};
        end
      end
    end
  end
endmodule

module keyed_sha1_mac_chk #(
  parameter int ROUNDS = 80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [159:0] digest
);
  logic [7:0] lat;
  always_ff @(posedge clk)
    if (!rst_n) lat <= '0;
    else if (!busy && start) lat <= '0;
    else if (busy) lat <= lat + 1'b1;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat == 8'(ROUNDS)));
  // R8
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(digest));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> (busy || done));
  // R6
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy);
endmodule

bind keyed_sha1_mac keyed_sha1_mac_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .digest(digest)
);

// File: tb/tb_keyed_sha1_mac.sv
module tb_keyed_sha1_mac;
  logic clk = 0, rst_n = 0;
  logic [63:0] key = '0, chal_in = '0, dev_addr = '0;
  logic chal_load = 0, use_addr = 0, start = 0;
  logic [159:0] digest;
  logic done;

  keyed_sha1_mac dut (.clk(clk), .rst_n(rst_n), .key(key), .chal_in(chal_in),
    .chal_load(chal_load), .dev_addr(dev_addr), .use_addr(use_addr),
    .start(start), .digest(digest), .done(done));

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  logic [63:0] model_chal = '0;
  logic [159:0] last_exp = '0;
  logic [159:0] exp_q [$];
  int due_q [$];
  string tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_mac(input logic [63:0] k, input logic [63:0] ch,
                                           input logic [63:0] ad, input logic ua);
    logic [31:0] w [80];
    logic [31:0] h0, h1, h2, h3, h4, ta, tb, tc, td, te, ff, kk, t;
    logic [63:0] fld;
    fld = ua ? ad : 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 16; i++) w[i] = 32'h0;
    w[0] = k[63:32]; w[1] = k[31:0]; w[2] = ch[63:32]; w[3] = ch[31:0];
    w[4] = fld[63:32]; w[5] = fld[31:0]; w[6] = 32'h80000000; w[15] = 32'd192;
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    h0 = 32'h67452301; h1 = 32'hEFCDAB89; h2 = 32'h98BADCFE; h3 = 32'h10325476; h4 = 32'hC3D2E1F0;
    ta = h0; tb = h1; tc = h2; td = h3; te = h4;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin ff = (tb & tc) | (~tb & td);           kk = 32'h5A827999; end
      else if (i < 40) begin ff = tb ^ tc ^ td;                     kk = 32'h6ED9EBA1; end
      else if (i < 60) begin ff = (tb & tc) | (tb & td) | (tc & td); kk = 32'h8F1BBCDC; end
      else             begin ff = tb ^ tc ^ td;                     kk = 32'hCA62C1D6; end
      t = rl(ta, 5) + ff + te + kk + w[i];
      te = td; td = tc; tc = rl(tb, 30); tb = ta; ta = t;
    end
    return {h0 + ta, h1 + tb, h2 + tc, h3 + td, h4 + te};
  endfunction

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && done) begin
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R7: actual=unexpected done expected=no done");
    end else begin
      string tg; logic [159:0] ev; int dv;
      ev = exp_q.pop_front(); dv = due_q.pop_front(); tg = tag_q.pop_front();
      check(tg, digest, ev);
      check("R6", 160'(cyc), 160'(dv));
    end
  end

  task automatic load_chal(input logic [63:0] v);
    @(negedge clk); chal_in = v; chal_load = 1;
    @(negedge clk); chal_load = 0;
    model_chal = v;
  endtask

  task automatic run_op(input string tg, input logic [63:0] k, input logic [63:0] ad,
                        input logic ua, input logic poke_start, input logic poke_load,
                        input logic [63:0] newch);
    logic [159:0] ev;
    @(negedge clk);
    key = k; dev_addr = ad; use_addr = ua; start = 1;
    ev = ref_mac(k, model_chal, ad, ua);
    exp_q.push_back(ev); due_q.push_back(cyc + 81); tag_q.push_back(tg);
    last_exp = ev;
    @(negedge clk); start = 0;
    key = ~k; dev_addr = ~ad; use_addr = ~ua;
    repeat (8) @(negedge clk);
    if (poke_start) begin start = 1; @(negedge clk); start = 0; end
    if (poke_load) begin chal_in = newch; chal_load = 1; @(negedge clk); chal_load = 0; model_chal = newch; end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", {159'(0), done}, 160'(0));
    check("R1", digest, 160'(0));
    rst_n = 1;
    @(negedge clk);
    // R4: no challenge loaded yet
    run_op("R4", 64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, 0, 0, 64'h0);
    // R2 / R5
    load_chal(64'hDEAD_BEEF_CAFE_F00D);
    run_op("R2", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0, 0, 0, 64'h0);
    // R3
    run_op("R3", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b1, 0, 0, 64'h0);
    run_op("R3", 64'hFFFF_0000_FFFF_0000, 64'h2800_0001_2345_6789, 1'b1, 0, 0, 64'h0);
    // R7: start while busy
    run_op("R7", 64'hA5A5_A5A5_5A5A_5A5A, 64'h0, 1'b0, 1, 0, 64'h0);
    // R9: challenge load mid-run
    run_op("R9", 64'h0F0F_0F0F_F0F0_F0F0, 64'h0000_0000_0000_0001, 1'b1, 0, 1, 64'h1357_9BDF_2468_ACE0);
    // R5: next run uses the new challenge
    run_op("R5", 64'h0F0F_0F0F_F0F0_F0F0, 64'h0000_0000_0000_0001, 1'b1, 0, 0, 64'h0);
    load_chal(64'h0);
    run_op("R5", 64'h0, 64'h0, 1'b0, 0, 0, 64'h0);
    // R8: digest holds while inputs move
    key = 64'h1; chal_in = 64'h2; dev_addr = 64'h3; use_addr = 1;
    repeat (20) @(negedge clk);
    check("R8", digest, last_exp);
    check("R8", {159'(0), done}, 160'(0));
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6: actual=%0d pending expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule